// File: doc/BRIEF.md
# Coherency-Attribute Memory Request Controller

This block sits between a processor's data cache and its system bus interface. For every memory access the cache hands it, it decides whether a bus transaction is needed and which one. It bases that choice on the 3-bit coherency attribute of the page the address falls in and on what the cache lookup found. The policies are: bypass the cache, fill without coherence, fill coherently with write-invalidate, fill coherently with write-update, and fill with exclusive ownership.

A single access is taken per handshake on the access side (`acc_valid`/`acc_ready`). Accesses that need no bus traffic retire in the cycle they are taken. Otherwise the controller latches a request and presents it on a valid/ready bus port until the bus takes it. It then holds `req_wait` until a one-cycle completion pulse arrives, so only one request is outstanding at any time.

A configuration input selects single-processor or multiprocessor operation. In single-processor operation only the bypass and noncoherent attributes are legal. Any other value raises a one-cycle error flag and the access is handled as noncoherent.

Top module: `coh_req_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `acc_ready` is 1 and `req_valid`, `req_wait` and `attr_err` are 0.
- R2: With page attribute code 2 (uncached), a load issues request code 1 (direct read) and a store issues request code 2 (direct write), whatever the hit and shared inputs are. The request carries the access address and the size code unchanged (0 partial word, 1 word, 2 partial doubleword, 3 doubleword).
- R3: With attribute code 3 (noncoherent), a load or store miss issues request code 3 (noncoherent block read).
- R4: With attribute code 4 (sharable) or code 6 (update), a load or store miss issues request code 4 (coherent block read without ownership).
- R5: With attribute code 5 (exclusive), a load or store miss issues request code 5 (coherent block read asking for exclusive ownership).
- R6: With attribute code 4 or 5, a store hit to a shared line issues request code 6 (invalidate).
- R7: With attribute code 6, a store hit to a shared line issues request code 7 (update).
- R8: A load hit, a store hit to an unshared line, or a store hit on a noncoherent page issues no request (`req_valid` stays 0). `acc_ready` is 1 again in the next cycle.
- R9: When `mp_mode` is 0, attribute codes 4, 5 and 6 are illegal, and codes 0, 1 and 7 are illegal in either mode. An accepted access with an illegal code sets `attr_err` for exactly the cycle after acceptance and is handled as code 3.
- R10: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_type`, `req_addr` and `req_size` hold their values.
- R11: After the bus accepts a request, `req_valid` is 0 and `req_wait` is 1. `acc_ready` stays 0 until the cycle after a `rsp_done` pulse. A `rsp_done` pulse at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mp_mode | input | 1 | 1 = multiprocessor, 0 = single processor |
| acc_valid | input | 1 | Access presented by the cache |
| acc_ready | output | 1 | Controller can take an access |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | Access size code |
| acc_addr | input | ADDR_W | Access address |
| acc_attr | input | 3 | Page coherency attribute |
| cache_hit | input | 1 | Cache lookup hit |
| line_shared | input | 1 | Hit line is in a shared state |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus takes the request |
| req_type | output | 3 | Bus request code |
| req_size | output | 2 | Size code of the request |
| req_addr | output | ADDR_W | Address of the request |
| rsp_done | input | 1 | Completion pulse from the bus |
| req_wait | output | 1 | A request is outstanding |
| attr_err | output | 1 | Illegal attribute seen on the last accepted access |

## Verification
An access is taken at a rising edge. The request code, address, size and the error flag all come from registers loaded at that edge, so they are due one edge later. The bench drives on falling edges and reads them at the next falling edge. Bus acceptance and completion each move the handshake state by one edge: `req_wait` is due the falling edge after `req_ready` is sampled high, and `acc_ready` the falling edge after the `rsp_done` pulse. Each check samples at those points, and the stretches where the bus stalls are checked once per cycle for stable outputs.

// File: rtl/coh_req_pkg.sv
package coh_req_pkg;

  localparam int ATTR_W = 3;

  localparam logic [ATTR_W-1:0] ATTR_UNC = 3'd2;
  localparam logic [ATTR_W-1:0] ATTR_NC  = 3'd3;
  localparam logic [ATTR_W-1:0] ATTR_SHR = 3'd4;
  localparam logic [ATTR_W-1:0] ATTR_EXC = 3'd5;
  localparam logic [ATTR_W-1:0] ATTR_UPD = 3'd6;

  typedef enum logic [2:0] {
    POL_BYPASS,
    POL_NONCOH,
    POL_INVAL,
    POL_UPDATE,
    POL_OWN
  } policy_e;

  typedef enum logic [2:0] {
    RQ_NONE      = 3'd0,
    RQ_RD_DIRECT = 3'd1,
    RQ_WR_DIRECT = 3'd2,
    RQ_BLK_NC    = 3'd3,
    RQ_BLK_COH   = 3'd4,
    RQ_BLK_OWN   = 3'd5,
    RQ_INVAL     = 3'd6,
    RQ_UPDATE    = 3'd7
  } req_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } state_e;

endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/coh_attr_decode.sv
module coh_attr_decode
  import coh_req_pkg::*;
(
  input  logic              mp_mode,
  input  logic [ATTR_W-1:0] attr,
  output policy_e           policy,
  output logic              illegal
);
  logic mp_only;
  logic known;

  always_comb begin
    mp_only = 1'b0;
    known   = 1'b1;
    policy  = POL_NONCOH;
    unique case (attr)
      ATTR_UNC: policy = POL_BYPASS;
      ATTR_NC:  policy = POL_NONCOH;
      ATTR_SHR: begin policy = POL_INVAL;  mp_only = 1'b1; end
      ATTR_EXC: begin policy = POL_OWN;    mp_only = 1'b1; end
      ATTR_UPD: begin policy = POL_UPDATE; mp_only = 1'b1; end
      default:  known = 1'b0;
    endcase
    illegal = !known || (mp_only && !mp_mode);
    if (illegal) policy = POL_NONCOH;
  end
endmodule

// File: rtl/coh_req_select.sv
module coh_req_select
  import coh_req_pkg::*;
(
  input  policy_e policy,
  input  logic    is_store,
  input  logic    hit,
  input  logic    shared,
  output req_e    code
);
  logic shared_store_hit;

  assign shared_store_hit = is_store && hit && shared;

  always_comb begin
    code = RQ_NONE;
    if (policy == POL_BYPASS) begin
      code = is_store ? RQ_WR_DIRECT : RQ_RD_DIRECT;
    end else if (!hit) begin
      unique case (policy)
        POL_NONCOH: code = RQ_BLK_NC;
        POL_OWN:    code = RQ_BLK_OWN;
        default:    code = RQ_BLK_COH;
      endcase
    end else if (shared_store_hit) begin
      unique case (policy)
        POL_INVAL, POL_OWN: code = RQ_INVAL;
        POL_UPDATE:         code = RQ_UPDATE;
        default:            code = RQ_NONE;
      endcase
    end
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_req_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  req_e              code,
  input  logic              code_err,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_type,
  output logic [1:0]        req_size,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_done,
  output logic              req_wait,
  output logic              attr_err
);
  state_e            state_q, state_d;
  logic [2:0]        type_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q, err_d;
  logic              accept;
  logic              load_en;

  assign accept  = acc_valid && (state_q == ST_IDLE);
  assign load_en = accept && (code != RQ_NONE);
  assign err_d   = accept && code_err;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (load_en)   state_d = ST_ISSUE;
      ST_ISSUE: if (req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (rsp_done)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= RQ_NONE;
      size_q <= '0;
      addr_q <= '0;
    end else if (load_en) begin
      type_q <= code;
      size_q <= acc_size;
      addr_q <= acc_addr;
    end
  end

  assign acc_ready = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_ISSUE);
  assign req_wait  = (state_q == ST_WAIT);
  assign req_type  = type_q;
  assign req_size  = size_q;
  assign req_addr  = addr_q;
  assign attr_err  = err_q;
endmodule

// File: rtl/coh_req_ctrl.sv
module coh_req_ctrl
  import coh_req_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mp_mode,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_store,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_attr,
  input  logic              cache_hit,
  input  logic              line_shared,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [2:0]        req_type,
  output logic [1:0]        req_size,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_done,
  output logic              req_wait,
  output logic              attr_err
);
  logic    rst_int_n;
  policy_e policy;
  logic    illegal;
  req_e    code;

  coh_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  coh_attr_decode u_dec (
    .mp_mode (mp_mode),
    .attr    (acc_attr),
    .policy  (policy),
    .illegal (illegal)
  );

  coh_req_select u_sel (
    .policy   (policy),
    .is_store (acc_store),
    .hit      (cache_hit),
    .shared   (line_shared),
    .code     (code)
  );

  coh_req_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_valid (acc_valid),
    .code      (code),
    .code_err  (illegal),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_ready (acc_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_type  (req_type),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rsp_done  (rsp_done),
    .req_wait  (req_wait),
    .attr_err  (attr_err)
  );
endmodule

// File: rtl/coh_req_ctrl_chk.sv
module coh_req_ctrl_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_type,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_done,
  input logic              req_wait,
  input logic              attr_err
);
  // R10
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_type) &&
                                   $stable(req_addr) && $stable(req_size)));

  // R11
  wait_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (req_wait && !req_valid && !acc_ready));

  // R11
  wait_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wait && !rsp_done) |=> req_wait);

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ready && (req_valid || req_wait)));

  // R9
  err_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attr_err |-> $past(acc_valid && acc_ready));

  // R8
  new_request_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(acc_valid && acc_ready));
endmodule

bind coh_req_ctrl coh_req_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_type  (req_type),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .rsp_done  (rsp_done),
  .req_wait  (req_wait),
  .attr_err  (attr_err)
);

// File: tb/coh_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_req_ctrl_tb_top;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mp_mode, acc_valid, acc_store, cache_hit, line_shared;
  logic [1:0]    acc_size;
  logic [AW-1:0] acc_addr;
  logic [2:0]    acc_attr;
  logic          req_ready, rsp_done;
  logic          acc_ready, req_valid, req_wait, attr_err;
  logic [2:0]    req_type;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  coh_req_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mp_mode(mp_mode),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_store(acc_store),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_attr(acc_attr),
    .cache_hit(cache_hit), .line_shared(line_shared),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_size(req_size), .req_addr(req_addr), .rsp_done(rsp_done),
    .req_wait(req_wait), .attr_err(attr_err)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_illegal(input bit mp, input logic [2:0] a);
    if (a == 3'd2 || a == 3'd3) return 1'b0;
    if (a == 3'd4 || a == 3'd5 || a == 3'd6) return !mp;
    return 1'b1;
  endfunction

  function automatic logic [2:0] f_code(input bit mp, input bit st, input logic [2:0] a,
                                        input bit hit, input bit sh);
    logic [2:0] e;
    e = f_illegal(mp, a) ? 3'd3 : a;
    if (e == 3'd2) return st ? 3'd2 : 3'd1;
    if (!hit) begin
      if (e == 3'd3) return 3'd3;
      if (e == 3'd5) return 3'd5;
      return 3'd4;
    end
    if (st && sh) begin
      if (e == 3'd4 || e == 3'd5) return 3'd6;
      if (e == 3'd6) return 3'd7;
    end
    return 3'd0;
  endfunction

  function automatic string f_tag(input logic [2:0] c);
    case (c)
      3'd1, 3'd2: return "R2";
      3'd3:       return "R3";
      3'd4:       return "R4";
      3'd5:       return "R5";
      3'd6:       return "R6";
      3'd7:       return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic access(input bit mp, input bit st, input logic [1:0] sz,
                        input logic [AW-1:0] ad, input logic [2:0] at,
                        input bit hit, input bit sh, input int rdly, input int ddly);
    logic [2:0] ec;
    bit         ee;
    ec = f_code(mp, st, at, hit, sh);
    ee = f_illegal(mp, at);
    @(negedge clk);
    check(acc_ready === 1'b1, "R11 ready before access", acc_ready, 1);
    mp_mode = mp; acc_store = st; acc_size = sz; acc_addr = ad;
    acc_attr = at; cache_hit = hit; line_shared = sh; acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check(attr_err === ee, "R9 error flag", attr_err, ee);
    if (ec == 3'd0) begin
      // R8: no bus request
      check(req_valid === 1'b0, "R8 no request", req_valid, 0);
      check(acc_ready === 1'b1, "R8 ready again", acc_ready, 1);
      @(negedge clk);
      check(attr_err === 1'b0, "R9 error one cycle", attr_err, 0);
    end else begin
      check(req_valid === 1'b1, f_tag(ec), req_valid, 1);
      check(req_type === ec, f_tag(ec), req_type, ec);
      check(req_addr === ad, "R2 address", req_addr, ad);
      check(req_size === sz, "R2 size", req_size, sz);
      check(acc_ready === 1'b0, "R11 busy", acc_ready, 0);
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        if (i == 0) check(attr_err === 1'b0, "R9 error one cycle", attr_err, 0);
        check(req_valid === 1'b1 && req_type === ec && req_addr === ad,
              "R10 hold", req_type, ec);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      check(req_valid === 1'b0 && req_wait === 1'b1, "R11 wait after accept",
            {req_valid, req_wait}, 2'b01);
      for (int i = 0; i < ddly; i++) begin
        @(negedge clk);
        check(req_wait === 1'b1 && acc_ready === 1'b0, "R11 wait holds", req_wait, 1);
      end
      rsp_done = 1'b1;
      @(negedge clk);
      rsp_done = 1'b0;
      check(acc_ready === 1'b1 && req_wait === 1'b0, "R11 done", acc_ready, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; mp_mode = 1'b1; acc_valid = 1'b0; acc_store = 1'b0;
    acc_size = '0; acc_addr = '0; acc_attr = 3'd3; cache_hit = 1'b0;
    line_shared = 1'b0; req_ready = 1'b0; rsp_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check(acc_ready === 1'b1 && req_valid === 1'b0 && req_wait === 1'b0 &&
          attr_err === 1'b0, "R1 in reset", {acc_ready, req_valid, req_wait, attr_err}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(acc_ready === 1'b1 && req_valid === 1'b0 && req_wait === 1'b0 &&
          attr_err === 1'b0, "R1 after release", {acc_ready, req_valid, req_wait, attr_err}, 4'b1000);

    // R11: stray completion pulse in idle is ignored
    rsp_done = 1'b1; @(negedge clk); rsp_done = 1'b0; @(negedge clk);
    check(acc_ready === 1'b1 && req_wait === 1'b0, "R11 stray done", acc_ready, 1);

    // Directed corners
    access(1, 0, 2'd3, 40'h00_1234_5678, 3'd2, 1, 1, 0, 0); // R2 load bypass, hit ignored
    access(1, 1, 2'd0, 40'hAB_CDEF_0001, 3'd2, 0, 0, 2, 1); // R2 store bypass
    access(0, 0, 2'd1, 40'h00_0000_0040, 3'd3, 0, 0, 1, 0); // R3
    access(1, 1, 2'd3, 40'h00_0000_0080, 3'd4, 0, 0, 0, 2); // R4 sharable
    access(1, 0, 2'd3, 40'h00_0000_00C0, 3'd6, 0, 0, 0, 0); // R4 update
    access(1, 1, 2'd3, 40'h00_0000_0100, 3'd5, 0, 0, 3, 0); // R5
    access(1, 1, 2'd2, 40'h00_0000_0140, 3'd4, 1, 1, 0, 0); // R6 sharable
    access(1, 1, 2'd2, 40'h00_0000_0180, 3'd5, 1, 1, 0, 0); // R6 exclusive
    access(1, 1, 2'd1, 40'h00_0000_01C0, 3'd6, 1, 1, 1, 1); // R7
    access(1, 0, 2'd1, 40'h00_0000_0200, 3'd4, 1, 1, 0, 0); // R8 load hit
    access(1, 1, 2'd1, 40'h00_0000_0240, 3'd6, 1, 0, 0, 0); // R8 unshared store hit
    access(1, 1, 2'd1, 40'h00_0000_0280, 3'd3, 1, 1, 0, 0); // R8 noncoherent store hit
    access(0, 0, 2'd3, 40'h00_0000_02C0, 3'd5, 0, 0, 0, 0); // R9 single-proc -> R3 fill
    access(0, 1, 2'd3, 40'h00_0000_0300, 3'd6, 1, 1, 0, 0); // R9 single-proc store hit, none
    access(1, 0, 2'd3, 40'h00_0000_0340, 3'd7, 0, 0, 0, 0); // R9 unused code
    access(1, 1, 2'd3, 40'h00_0000_0380, 3'd0, 1, 1, 0, 0); // R9 unused code, hit

    // Random mix
    for (int n = 0; n < 400; n++) begin
      access($urandom_range(1, 0), $urandom_range(1, 0), 2'($urandom_range(3, 0)),
             {8'($urandom), $urandom}, 3'($urandom_range(7, 0)),
             $urandom_range(1, 0), $urandom_range(1, 0),
             $urandom_range(3, 0), $urandom_range(3, 0));
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule